// File: doc/BRIEF.md
# Duty-Cycle Phase Detector

This block compares a local-oscillator square wave (`lo_in`) with a reference square wave (`ref_in`). It produces the two control pulses, `up` and `down`, that a charge pump uses to steer an oscillator. Both inputs are asynchronous to `clk`, which runs much faster than either input. Each input passes through a synchroniser. The block then detects edges on the synchronised copies.

Once the block is armed, `up` and `down` rise together on the first cycle in which both synchronised inputs are high. After that, each pulse ends on the falling edge of its own input. Whichever pulse lasts longer identifies the input that fell last. If `up` outlasts `down`, the oscillator runs slow. In lock both pulses sit near half duty.

A signed count of the cycles in which `up` alone is high, minus the cycles in which `down` alone is high, is collected over each reference period. That count is published as `phase_err`.

Top module: `phase_duty_det`

## Requirements
- R1: While `rst_n` is low, and after reset until the first event, `up` and `down` are 0 and `phase_err` is 0.
- R2: When the block is armed and both inputs are high, `up` and `down` rise on the same clock edge. That edge is the third rising edge of `clk` that samples both inputs high, counting the first sampling edge. Out of reset the block is armed.
- R3: `up` falls on the third clock edge that samples `lo_in` low after it was high, whatever `ref_in` does.
- R4: `down` falls on the third clock edge that samples `ref_in` low after it was high, whatever `lo_in` does.
- R5: The two falls are handled independently and may come in either order. A later fall of `ref_in` leaves `down` high longer than `up`.
- R6: After a pulse pair starts, no new pulse pair starts until both synchronised inputs have been low in the same cycle. A dip and return of only one input has no effect on `up` or `down`.
- R7: `phase_err` is a two's-complement value of `PE_W` bits. It changes only on the third clock edge after `ref_in` is first sampled high following a low sample. At that edge it takes the count accumulated since the previous such edge: +1 for each cycle with `up`=1 and `down`=0, and −1 for each cycle with `up`=0 and `down`=1.
- R8: The running count saturates at +(2^(PE_W−1)−1) and −2^(PE_W−1) instead of wrapping.
- R9: `phase_err` is positive when `lo_in` stays high longer than `ref_in`, negative when it stays high for less time, and zero when both stay high for equal times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_in | input | 1 | Local-oscillator square wave, asynchronous |
| ref_in | input | 1 | Reference square wave, asynchronous |
| up | output | 1 | Raise-frequency pulse to the charge pump |
| down | output | 1 | Lower-frequency pulse to the charge pump |
| phase_err | output | PE_W | Signed up-minus-down count of the last reference period |

## Verification
A stale arming flag shows up within one input period. It appears as a pulse pair that starts while one input is still high from the last pair, or as a pair that never starts. In either case the mismatch is at `up` and `down` within three clocks of the input change. A wrong synchroniser depth or a wrong edge history moves a rise or fall of the outputs by a whole cycle, and the bench's comparison on every clock catches it at once. A fault in the window counter stays hidden until the next reference rise publishes it on `phase_err`, so saturation is driven deliberately with a long one-sided window.

// File: rtl/phase_duty_det.sv
module phase_duty_det #(
  parameter int PE_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lo_in,
  input  logic                   ref_in,
  output logic                   up,
  output logic                   down,
  output logic signed [PE_W-1:0] phase_err
);

  localparam int SH_W = SYNC_STAGES + 1;
  localparam logic signed [PE_W-1:0] CNT_MAX = {1'b0, {(PE_W-1){1'b1}}};
  localparam logic signed [PE_W-1:0] CNT_MIN = {1'b1, {(PE_W-1){1'b0}}};
  localparam logic signed [PE_W-1:0] ONE     = PE_W'(1);

  logic [SH_W-1:0] lo_sh, ref_sh;
  logic lo_s, lo_p, ref_s, ref_p;
  logic lo_fall, ref_fall, ref_rise, both_hi, both_lo;
  logic armed, fire, up_q, dn_q;
  logic signed [PE_W-1:0] acc, acc_step, acc_seed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_sh  <= '0;
      ref_sh <= '0;
    end else begin
      lo_sh  <= {lo_sh[SH_W-2:0], lo_in};
      ref_sh <= {ref_sh[SH_W-2:0], ref_in};
    end

  assign lo_s     = lo_sh[SYNC_STAGES-1];
  assign lo_p     = lo_sh[SYNC_STAGES];
  assign ref_s    = ref_sh[SYNC_STAGES-1];
  assign ref_p    = ref_sh[SYNC_STAGES];
  assign lo_fall  = lo_p & ~lo_s;
  assign ref_fall = ref_p & ~ref_s;
  assign ref_rise = ref_s & ~ref_p;
  assign both_hi  = lo_s & ref_s;
  assign both_lo  = ~lo_s & ~ref_s;
  assign fire     = armed & both_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b1;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      if (fire)         armed <= 1'b0;
      else if (both_lo) armed <= 1'b1;
      if (fire)         up_q <= 1'b1;
      else if (lo_fall) up_q <= 1'b0;
      if (fire)          dn_q <= 1'b1;
      else if (ref_fall) dn_q <= 1'b0;
    end

  assign up   = up_q;
  assign down = dn_q;

  always_comb begin
    acc_step = acc;
    acc_seed = '0;
    if (up_q && !dn_q) begin
      acc_seed = ONE;
      if (acc != CNT_MAX) acc_step = acc + ONE;
    end else if (dn_q && !up_q) begin
      acc_seed = -ONE;
      if (acc != CNT_MIN) acc_step = acc - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc       <= '0;
      phase_err <= '0;
    end else if (ref_rise) begin
      phase_err <= acc;
      acc       <= acc_seed;
    end else begin
      acc <= acc_step;
    end

  p_rise_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> ($rose(dn_q) && $past(lo_s && ref_s)));
  p_rise_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(armed));
  p_up_fall_on_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_q) |-> $past(lo_p && !lo_s));
  p_dn_fall_on_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_q) |-> $past(ref_p && !ref_s));
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rise |=> $stable(phase_err));
  p_acc_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc) == CNT_MAX && !$past(ref_rise)) |-> acc != CNT_MIN);

endmodule

// File: tb/phase_duty_det_tb.sv
`timescale 1ns/1ps
module phase_duty_det_tb;
  localparam int PE_W = 8;
  localparam int EMAX = 127;
  localparam int EMIN = -128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_in = 1'b0;
  logic ref_in = 1'b0;
  logic up, down;
  logic signed [PE_W-1:0] phase_err;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  phase_duty_det #(.PE_W(PE_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .lo_in(lo_in), .ref_in(ref_in),
    .up(up), .down(down), .phase_err(phase_err));

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit lo_q[$]  = '{0, 0, 0};
  bit ref_q[$] = '{0, 0, 0};
  bit m_up = 0, m_dn = 0, m_arm = 1;
  int m_acc = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      lo_q = '{0, 0, 0}; ref_q = '{0, 0, 0};
      m_up = 0; m_dn = 0; m_arm = 1; m_acc = 0; m_err = 0;
    end else begin
      bit ln, lp, rn, rp, go;
      int d;
      ln = lo_q[1]; lp = lo_q[2]; rn = ref_q[1]; rp = ref_q[2];
      d = (m_up && !m_dn) ? 1 : ((m_dn && !m_up) ? -1 : 0);
      if (rn && !rp) begin
        m_err = m_acc; m_acc = d;
      end else begin
        m_acc = m_acc + d;
        if (m_acc > EMAX) m_acc = EMAX;
        if (m_acc < EMIN) m_acc = EMIN;
      end
      go = m_arm && ln && rn;
      if (go) begin m_up = 1; m_dn = 1; m_arm = 0; end
      else begin
        if (lp && !ln) m_up = 0;
        if (rp && !rn) m_dn = 0;
        if (!ln && !rn) m_arm = 1;
      end
      lo_q.push_front(lo_in);   void'(lo_q.pop_back());
      ref_q.push_front(ref_in); void'(ref_q.pop_back());
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, "up", up, m_up);
    check(cur_req, "down", down, m_dn);
    check(cur_req, "phase_err", phase_err, m_err);
  end

  task automatic drive(bit l, bit r, int n);
    @(negedge clk);
    lo_in = l; ref_in = r;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic periods(int lo_hi, int ref_hi, int per, int cnt);
    for (int p = 0; p < cnt; p++)
      for (int t = 0; t < per; t++) begin
        @(negedge clk);
        lo_in = (t < lo_hi); ref_in = (t < ref_hi);
      end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
      begin
        repeat (4) @(negedge clk);
        check("R1", "up in reset", up, 0);
        check("R1", "down in reset", down, 0);
        check("R1", "err in reset", phase_err, 0);
        rst_n = 1'b1;
        drive(0, 0, 4);
        check("R1", "err after reset", phase_err, 0);

        cur_req = "R2";
        @(negedge clk); lo_in = 1; ref_in = 1;
        repeat (2) @(negedge clk);
        check("R2", "up before latency", up, 0);
        @(negedge clk);
        check("R2", "up at latency", up, 1);
        check("R2", "down at latency", down, 1);
        drive(1, 1, 5);

        cur_req = "R3";
        @(negedge clk); lo_in = 0;
        repeat (3) @(negedge clk);
        check("R3", "up after lo fall", up, 0);
        check("R3", "down kept", down, 1);
        cur_req = "R4";
        @(negedge clk); ref_in = 0;
        repeat (3) @(negedge clk);
        check("R4", "down after ref fall", down, 0);
        drive(0, 0, 6);

        cur_req = "R9";
        periods(10, 10, 20, 5);
        check("R9", "lock error zero", phase_err, 0);
        periods(12, 10, 20, 5);
        check("R9", "lo late positive", phase_err, 2);
        cur_req = "R5";
        periods(9, 12, 20, 5);
        check("R5", "ref late negative", phase_err, -3);

        cur_req = "R6";
        drive(0, 0, 4);
        drive(1, 1, 6);
        drive(0, 1, 6);
        drive(1, 1, 6);
        check("R6", "no refire without both low", up, 0);
        drive(0, 0, 3);
        drive(1, 1, 4);
        check("R6", "refire after both low up", up, 1);
        check("R6", "refire after both low down", down, 1);
        drive(0, 0, 6);

        cur_req = "R8";
        drive(1, 1, 4);
        drive(1, 0, 300);
        drive(1, 1, 6);
        check("R8", "positive saturation", phase_err, EMAX);
        drive(0, 0, 4);
        drive(1, 1, 4);
        drive(0, 1, 300);
        drive(0, 0, 2);
        drive(0, 1, 6);
        check("R8", "negative saturation", phase_err, EMIN);

        cur_req = "R7";
        drive(0, 0, 4);
        periods(15, 5, 25, 4);
        check("R7", "window count", phase_err, 10);
        drive(0, 0, 30);
        check("R7", "held without ref rise", phase_err, 10);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule